// File: doc/BRIEF.md
# Systolic Suffix-Array Sorter

This block takes a short string held in its own character store and returns its suffix array. The suffix array is the list of suffix start positions, ordered so that the suffixes they name are in lexicographic order. Software or an upstream stage writes the string through a load port and pulses `start`. When the sort is finished, `done` goes high and the sorted indices come out one per cycle with a valid strobe.

The sort runs on a linear chain of register cells. Each cell holds a suffix address and the character that address currently points at. A comparator sits between every pair of neighbouring cells. A per-position boundary bit marks where one group of still-tied suffixes ends and the next begins. A sequencer broadcasts the same command to every comparator.

Each pass has four steps:
- Odd-even compare/swap rounds order every group by its current character.
- The boundary bits are refined.
- If every position is now a boundary, the sort is complete.
- Otherwise the whole chain is rotated through one end. Each entry leaves the chain, has its address advanced by one and its next character fetched, and re-enters at the other end. The rotation direction reverses on every pass.

Because every pass advances each stored address by one, the true index is the stored address minus the number of passes.

Top module: `sus_sorter`

## Requirements
- R1: After reset, `done` and `res_valid` are low.
- R2: While the block is idle, a cycle with `ld_we` high stores `ld_char` at string position `ld_idx`. The string is LEN characters long, and every character must be non-zero.
- R3: The output lists the LEN suffix start positions in ascending lexicographic order of the suffixes. For this ordering, every position past the end of the string reads as character 0, so a shorter suffix sorts before any longer suffix that it prefixes. Example: for "ABADCAB!" the result is 7 5 0 2 6 1 4 3.
- R4: `res_valid` is high for exactly LEN consecutive cycles. It rises in the same cycle as `done`, and it carries the smallest suffix first, one index per cycle on `res_idx`.
- R5: A `start` accepted while idle clears `done`. Once `done` is set, it stays high until the next accepted `start`.
- R6: Let N = LEN. Let D be the smallest k ≥ 0 such that all suffix prefixes of length k+1 (zero-padded) are distinct. Then `done` rises N+2+D·(2N+1) clock edges after the edge that accepted `start`, and D never exceeds N−1.
- R7: `start` and `ld_we` are ignored while a sort or its output stream is in progress. In particular, the stored string is left unchanged.
- R8: Strings with long runs of equal characters, such as a string of one repeated letter, sort correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | String write strobe |
| ld_idx | input | $clog2(LEN) | String position to write |
| ld_char | input | CW | Character to write (non-zero) |
| start | input | 1 | Begin sorting the stored string |
| done | output | 1 | Sort finished; held until the next accepted start |
| res_valid | output | 1 | `res_idx` carries a result this cycle |
| res_idx | output | $clog2(LEN) | Suffix start position, in sorted order |

## Verification
The assertions assume that every stored character is non-zero. Under that assumption the zero read past the end is unique, and the refinement finishes within LEN−1 passes; the pass-count and boundary-bit properties depend on this. They also assume that reset is held for at least one edge before the first `start`. The stimulus writes only printable, non-zero characters, and it writes only full strings while the block is idle. The only stimulus given during a run is the deliberate `start` and load pokes that check R7.

// File: rtl/sus_pkg.sv
package sus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_SORT, ST_MARK, ST_FETCH, ST_OUT
  } st_t;

  // Broadcast command and per-cell multiplexer codes share one encoding.
  localparam logic [1:0] CMD_SHR  = 2'b00;  // take left neighbour
  localparam logic [1:0] CMD_IDLE = 2'b01;  // keep own value
  localparam logic [1:0] CMD_CMP  = 2'b10;  // compare/swap (cell code: keep)
  localparam logic [1:0] CMD_SHL  = 2'b11;  // take right neighbour
endpackage

// File: rtl/sus_cell.sv
module sus_cell #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   code,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] from_l,
  input  logic [W-1:0] from_r,
  output logic [W-1:0] q
);
  import sus_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)            q <= '0;
    else if (ld_en)        q <= ld_val;
    else if (code == CMD_SHR) q <= from_l;
    else if (code == CMD_SHL) q <= from_r;
  end
endmodule

// File: rtl/sus_pair.sv
module sus_pair #(
  parameter int CW = 8
) (
  input  logic [1:0]    cmd,
  input  logic          active,
  input  logic [CW-1:0] l_ch,
  input  logic [CW-1:0] r_ch,
  input  logic          r_bnd,
  output logic [1:0]    code_l,
  output logic [1:0]    code_r
);
  import sus_pkg::*;

  always_comb begin
    code_l = CMD_IDLE;
    code_r = CMD_IDLE;
    case (cmd)
      CMD_SHR: begin code_l = CMD_SHR; code_r = CMD_SHR; end
      CMD_SHL: begin code_l = CMD_SHL; code_r = CMD_SHL; end
      CMD_CMP: begin
        // swap only inside a group (no boundary at the right cell)
        if (active && !r_bnd && (l_ch > r_ch)) begin
          code_l = CMD_SHL;
          code_r = CMD_SHR;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sus_seq.sv
module sus_seq #(
  parameter int LEN = 8,
  parameter int AW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            all_set,
  output sus_pkg::st_t    st,
  output logic [1:0]      cmd,
  output logic            phase,
  output logic [AW-1:0]   pass,
  output logic            done
);
  import sus_pkg::*;

  localparam int CNW = $clog2(LEN);
  localparam logic [CNW-1:0] CNT_LAST = CNW'(LEN - 1);

  logic [CNW-1:0] cnt_q;
  logic           dir_q;
  logic           last;

  assign last  = (cnt_q == CNT_LAST);
  assign phase = cnt_q[0];

  always_comb begin
    case (st)
      ST_SORT:  cmd = CMD_CMP;
      ST_FETCH: cmd = dir_q ? CMD_SHL : CMD_SHR;
      ST_OUT:   cmd = CMD_SHL;
      default:  cmd = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt_q <= '0;
      dir_q <= 1'b0;
      pass  <= '0;
      done  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin st <= ST_INIT; done <= 1'b0; end
        ST_INIT: begin
          st <= ST_SORT; cnt_q <= '0; pass <= '0; dir_q <= 1'b0;
        end
        ST_SORT: begin
          if (last) begin st <= ST_MARK; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_MARK: begin
          cnt_q <= '0;
          if (all_set) begin st <= ST_OUT; done <= 1'b1; end
          else st <= ST_FETCH;
        end
        ST_FETCH: begin
          if (last) begin
            st <= ST_SORT; cnt_q <= '0; pass <= pass + 1'b1; dir_q <= ~dir_q;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_OUT: begin
          if (last) begin st <= ST_IDLE; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sus_sorter.sv
module sus_sorter #(
  parameter int LEN = 8,
  parameter int CW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_we,
  input  logic [$clog2(LEN)-1:0]  ld_idx,
  input  logic [CW-1:0]           ld_char,
  input  logic                    start,
  output logic                    done,
  output logic                    res_valid,
  output logic [$clog2(LEN)-1:0]  res_idx
);
  import sus_pkg::*;

  localparam int IW = $clog2(LEN);
  localparam int AW = IW + 2;
  localparam int W  = AW + CW;
  localparam logic [AW-1:0] LEN_A = AW'(LEN);

  logic [CW-1:0] mem_q [LEN];
  logic [W-1:0]  q     [LEN];
  logic [LEN-1:0] bnd_q, bnd_nx;
  logic [1:0]    code_l [LEN-1];
  logic [1:0]    code_r [LEN-1];
  logic [1:0]    code   [LEN];
  st_t           st_w;
  logic [1:0]    cmd_w;
  logic          phase_w;
  logic [AW-1:0] pass_w;
  logic          all_set;
  logic [W-1:0]  left_in, right_in;

  // Character at an address; positions past the end read as zero.
  function automatic logic [CW-1:0] rd_char(input logic [AW-1:0] a);
    rd_char = (a < LEN_A) ? mem_q[a[IW-1:0]] : '0;
  endfunction

  // Entry advanced to its next character.
  function automatic logic [W-1:0] refetch(input logic [W-1:0] e);
    logic [AW-1:0] na;
    na = e[W-1:CW] + 1'b1;
    refetch = {na, rd_char(na)};
  endfunction

  // True suffix index from a stored address and the pass count.
  function automatic logic [IW-1:0] true_idx(input logic [AW-1:0] a,
                                             input logic [AW-1:0] p);
    logic [AW-1:0] d;
    d = a - p;
    true_idx = d[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) mem_q[i] <= '0;
    end else if (ld_we && st_w == ST_IDLE) begin
      mem_q[ld_idx] <= ld_char;
    end
  end

  sus_seq #(.LEN(LEN), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .all_set(all_set),
    .st(st_w), .cmd(cmd_w), .phase(phase_w), .pass(pass_w), .done(done)
  );

  assign left_in  = refetch(q[LEN-1]);
  assign right_in = (st_w == ST_OUT) ? '0 : refetch(q[0]);

  genvar g;
  generate
    for (g = 0; g < LEN - 1; g++) begin : g_pair
      localparam logic PAR = 1'(g % 2);
      sus_pair #(.CW(CW)) u_pair (
        .cmd(cmd_w), .active(phase_w == PAR),
        .l_ch(q[g][CW-1:0]), .r_ch(q[g+1][CW-1:0]), .r_bnd(bnd_q[g+1]),
        .code_l(code_l[g]), .code_r(code_r[g])
      );
    end

    for (g = 0; g < LEN; g++) begin : g_cell
      if (g == 0) begin : g_first
        assign code[g] = code_l[0];
      end else if (g == LEN - 1) begin : g_last
        assign code[g] = code_r[g-1];
      end else begin : g_mid
        assign code[g] = (code_r[g-1] != CMD_IDLE) ? code_r[g-1] : code_l[g];
      end
      sus_cell #(.W(W)) u_cell (
        .clk(clk), .rst_n(rst_n), .code(code[g]),
        .ld_en(st_w == ST_INIT), .ld_val({AW'(g), mem_q[g]}),
        .from_l((g == 0) ? left_in : q[(g == 0) ? 0 : g-1]),
        .from_r((g == LEN - 1) ? right_in : q[(g == LEN - 1) ? g : g+1]),
        .q(q[g])
      );
      if (g == 0) begin : g_b0
        assign bnd_nx[g] = 1'b1;
      end else begin : g_bn
        assign bnd_nx[g] = bnd_q[g] | (q[g][CW-1:0] != q[g-1][CW-1:0]);
      end
    end
  endgenerate

  assign all_set = &bnd_nx;

  always_ff @(posedge clk) begin
    if (!rst_n)                bnd_q <= '0;
    else if (st_w == ST_INIT)  bnd_q <= LEN'(1);
    else if (st_w == ST_MARK)  bnd_q <= bnd_nx;
  end

  assign res_valid = (st_w == ST_OUT);
  assign res_idx   = true_idx(q[0][W-1:CW], pass_w);
endmodule

// File: rtl/sus_chk.sv
module sus_chk #(
  parameter int LEN = 8,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic           res_valid,
  input sus_pkg::st_t   st,
  input logic [LEN-1:0] bnd,
  input logic [AW-1:0]  pass
);
  import sus_pkg::*;

  localparam int VW = $clog2(LEN) + 1;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || st == ST_INIT) vcnt <= '0;
    else if (res_valid)          vcnt <= vcnt + 1'b1;
  end

  AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done);                                          // R4
  AST_DONE_STARTS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> res_valid);                                   // R4
  AST_STREAM_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (vcnt < VW'(LEN)));                             // R4
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                   // R5
  AST_BOUNDARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_INIT) |=> (($past(bnd) & ~bnd) == '0));             // R3
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pass <= AW'(LEN - 1));                                        // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !res_valid);                              // R7
endmodule

bind sus_sorter sus_chk #(.LEN(LEN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .res_valid(res_valid), .st(st_w), .bnd(bnd_q), .pass(pass_w)
);

// File: tb/sus_sorter_bench.sv
module sus_sorter_bench;
  localparam int LEN = 8;
  localparam int IW  = $clog2(LEN);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [7:0]    ld_char = '0;
  logic          start = 1'b0;
  logic          done, res_valid;
  logic [IW-1:0] res_idx;

  int n_chk = 0;
  int n_bad = 0;
  int ref_sa [LEN];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sus_sorter #(.LEN(LEN), .CW(8)) u_sus_sorter (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx),
    .ld_char(ld_char), .start(start), .done(done),
    .res_valid(res_valid), .res_idx(res_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int chr(input string s, input int p);
    return (p < LEN) ? int'(s[p]) : 0;
  endfunction

  // -1 / 0 / 1 comparison of the suffixes at a and b, zero past the end.
  function automatic int suf_cmp(input string s, input int a, input int b);
    for (int k = 0; k <= LEN; k++) begin
      if (chr(s, a + k) < chr(s, b + k)) return -1;
      if (chr(s, a + k) > chr(s, b + k)) return 1;
    end
    return 0;
  endfunction

  task automatic build_ref(input string s, output int dpass);
    int tmp;
    for (int i = 0; i < LEN; i++) ref_sa[i] = i;
    for (int i = 1; i < LEN; i++)
      for (int j = i; j > 0; j--)
        if (suf_cmp(s, ref_sa[j-1], ref_sa[j]) > 0) begin
          tmp = ref_sa[j]; ref_sa[j] = ref_sa[j-1]; ref_sa[j-1] = tmp;
        end
    dpass = LEN - 1;
    for (int k = LEN - 1; k >= 0; k--) begin
      bit uniq = 1'b1;
      for (int a = 0; a < LEN; a++)
        for (int b = a + 1; b < LEN; b++) begin
          bit same = 1'b1;
          for (int m = 0; m <= k; m++)
            if (chr(s, a + m) != chr(s, b + m)) same = 1'b0;
          if (same) uniq = 1'b0;
        end
      if (uniq) dpass = k;
    end
  endtask

  task automatic load_str(input string s);  // R2
    for (int i = 0; i < LEN; i++) begin
      ld_we = 1'b1; ld_idx = IW'(i); ld_char = s[i];
      @(posedge clk); #1;
    end
    ld_we = 1'b0;
  endtask

  // Cycle-by-cycle comparison against the behavioural model.
  task automatic run(input string s, input string tag, input bit poke);
    int dp, lat;
    build_ref(s, dp);
    lat = LEN + 2 + dp * (2 * LEN + 1);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R5 done cleared", int'(done), 0);
    for (int n = 1; n <= lat + LEN + 1; n++) begin
      @(posedge clk); #1;
      start = 1'b0; ld_we = 1'b0;
      check("R6 done timing", int'(done), (n >= lat) ? 1 : 0);
      check("R4 valid window", int'(res_valid),
            (n >= lat && n < lat + LEN) ? 1 : 0);
      if (res_valid && n >= lat && n < lat + LEN)
        check({tag, " index"}, int'(res_idx), ref_sa[n - lat]);
      if (poke && (n == 3 || n == lat + 2)) begin  // R7 pokes while busy
        start = 1'b1; ld_we = 1'b1; ld_idx = '0; ld_char = 8'h5A;
      end
    end
    repeat (3) begin
      @(posedge clk); #1;
      check("R5 done held", int'(done), 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 done reset", int'(done), 0);
    check("R1 valid reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    load_str("ABADCAB!");
    run("ABADCAB!", "R3 R2", 1'b0);
    check("R3 example", ref_sa[0] * 10 + ref_sa[1], 75);
    load_str("AAAAAAAA");
    run("AAAAAAAA", "R8", 1'b0);
    load_str("HGFEDCBA");
    run("HGFEDCBA", "R3 desc", 1'b0);
    load_str("ABABABAB");
    run("ABABABAB", "R8 period", 1'b0);
    load_str("BANANAS!");
    run("BANANAS!", "R7 poked", 1'b1);
    run("BANANAS!", "R7 kept string", 1'b0);
    load_str("ZYXAZYXB");
    run("ZYXAZYXB", "R2 reload", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule